// File: doc/BRIEF.md
# Four-Phase DMA Bus Cycle Sequencer

This block is a bus-master engine that runs single memory cycles on a 16-bit multiplexed address/data bus. A requester presents an address, a direction, a byte/word choice and write data, then raises `start`. If the bus grant is held, the block runs a fixed sequence of bus-clock phases. T1 carries the address and pulses the address strobe. T2 and T3 carry data with the read or write strobe active. An optional wait phase TW follows T3 when `ready` is high there. T4 completes the cycle and raises `done`.

In byte mode, only the low half of the bus carries data. The high half keeps driving address bits 15..8 through the data phases. In 32-bit addressing mode, an upper-address strobe pulses during T1 while bits 31..16 of the request address are presented on `up_addr`. Every output enable stays low while the grant is absent.

The phase machine has the states IDLE, T1, T2, T3, TW and T4. Its transitions are:
- IDLE to T1 on an accepted start.
- T1 to T2, and T2 to T3, always.
- T3 to TW when `ready` is high.
- T3 to T4 when `ready` is low.
- TW to T4, always.
- T4 to T1 on an accepted start.
- T4 to IDLE otherwise.

Top module: `dma_cycle_seq`

## Requirements
- R1: After reset the sequencer is IDLE. In that state `rd_n` and `wr_n` are 1, `astb`, `hi_astb` and `done` are 0, and `rdata` is 0.
- R2: A start is accepted only when `start` and `bus_grant` are both high while the sequencer is IDLE or in T4. The request fields are latched at that edge and T1 follows in the next cycle. A start in any other state has no effect.
- R3: In T1 the bus drives `req_addr[15:0]` on all 16 bits, and `astb` is 1. `astb` is 0 in every other phase.
- R4: In word mode, during T2, T3, TW and T4, a write drives `req_wdata[15:0]` on all 16 bits. A read releases both bus halves.
- R5: In byte mode, during T2, T3, TW and T4, the high half is driven with `req_addr[15:8]`. The low half carries `req_wdata[7:0]` for a write and is released for a read.
- R6: For a write, `wr_n` is 0 in T2, T3 and TW, and 1 in T4 and all other phases. Write data stays driven through T4. `rd_n` and `wr_n` are never both 0.
- R7: For a read, `rd_n` is 0 in T2, T3 and TW. `rdata` takes `bus_in` at the clock edge that ends the last low phase of `rd_n`. In byte mode the value is `bus_in[7:0]` zero-extended. Otherwise `rdata` holds its value.
- R8: `ready` is sampled only in T3. When it is 1 there, exactly one wait phase TW is inserted before T4. In every other phase `ready` is ignored.
- R9: `bus_oe_lo`, `bus_oe_hi`, `ctl_oe` and `hi_astb_oe` are all 0 while `bus_grant` is 0. If the grant drops mid-cycle, the enables drop and the phase sequence continues.
- R10: When the latched request has 32-bit mode set, `hi_astb` is 1 in T1 and `up_addr` shows `req_addr[31:16]`. `hi_astb_oe` equals `bus_grant` AND the latched 32-bit flag.
- R11: `done` is 1 exactly in T4. A start accepted in T4 enters T1 in the next cycle with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_grant | input | 1 | Bus acknowledge; enables all outputs |
| start | input | 1 | Request a memory cycle |
| req_addr | input | 32 | Cycle address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte mode, 0 = word mode |
| req_wide | input | 1 | 1 = 32-bit addressing (upper strobe used) |
| req_wdata | input | 16 | Write data |
| ready | input | 1 | Wait request, sampled in T3 |
| bus_in | input | 16 | Bus value seen on reads |
| bus_out | output | 16 | Value driven onto the bus |
| bus_oe_lo | output | 1 | Drive enable, bus bits 7..0 |
| bus_oe_hi | output | 1 | Drive enable, bus bits 15..8 |
| astb | output | 1 | Address strobe (high in T1) |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ctl_oe | output | 1 | Drive enable for astb, rd_n, wr_n |
| hi_astb | output | 1 | Upper-address strobe |
| hi_astb_oe | output | 1 | Drive enable for hi_astb and up_addr |
| up_addr | output | 16 | Upper address bits 31..16 |
| rdata | output | 16 | Captured read data |
| done | output | 1 | One-cycle completion pulse in T4 |

## Verification
The assertions watch the phase graph on every cycle:
- T1, T2 and T3 always advance.
- The branch at T3 follows `ready`.
- TW always leads to T4.
- The strobes are mutually exclusive, and `rdata` moves only on entry to T4.

Only the bench's scenarios can show the data side of the cycle. That covers which request fields are latched and which bus halves carry address or data in each mode. It also covers the zero-extension of byte reads and the exact edge at which `bus_in` is captured, shown by changing `bus_in` every cycle. Finally, it covers ignored starts during a cycle and enable behaviour when the grant drops.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    parameter int BUS_W  = 16;
    parameter int HALF_W = BUS_W / 2;
    parameter int ADDR_W = 2 * BUS_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_T1,
        PH_T2,
        PH_T3,
        PH_TW,
        PH_T4
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic              byte_m;
        logic              wide;
        logic [BUS_W-1:0]  wdata;
    } req_t;
endpackage

// File: rtl/dma_phase_fsm.sv
module dma_phase_fsm
    import dma_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   grant,
    input  logic   start,
    input  logic   ready,
    input  req_t   req_in,
    output phase_e phase,
    output req_t   cur
);
    phase_e nxt;
    logic   accept;

    assign accept = start && grant && (phase == PH_IDLE || phase == PH_T4);

    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_IDLE: nxt = accept ? PH_T1 : PH_IDLE;
            PH_T1:   nxt = PH_T2;
            PH_T2:   nxt = PH_T3;
            PH_T3:   nxt = ready ? PH_TW : PH_T4;
            PH_TW:   nxt = PH_T4;
            PH_T4:   nxt = accept ? PH_T1 : PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            phase <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (accept) begin
            cur <= req_in;
        end
    end

    assert_t1_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_T1 |=> phase == PH_T2);
    assert_t2_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_T2 |=> phase == PH_T3);
    assert_wait_ins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T3 && ready) |=> phase == PH_TW);
    assert_no_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T3 && !ready) |=> phase == PH_T4);
    assert_single_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_TW |=> phase == PH_T4);
    assert_b2b_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T4 && start && grant) |=> phase == PH_T1);
    assert_busy_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase inside {PH_T1, PH_T2, PH_T3, PH_TW}) |=> $stable(cur));
endmodule

// File: rtl/dma_bus_drive.sv
module dma_bus_drive
    import dma_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant,
    input  phase_e           phase,
    input  req_t             cur,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe_lo,
    output logic             bus_oe_hi,
    output logic             astb,
    output logic             rd_n,
    output logic             wr_n,
    output logic             ctl_oe,
    output logic             hi_astb,
    output logic             hi_astb_oe,
    output logic [BUS_W-1:0] up_addr,
    output logic             done
);
    logic lo_en, hi_en;
    logic [BUS_W-1:0] data_word;

    assign data_word = {cur.byte_m ? cur.addr[BUS_W-1:HALF_W] : cur.wdata[BUS_W-1:HALF_W],
                        cur.wdata[HALF_W-1:0]};

    always_comb begin
        bus_out = '0;
        lo_en   = 1'b0;
        hi_en   = 1'b0;
        astb    = 1'b0;
        hi_astb = 1'b0;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        done    = 1'b0;
        unique case (phase)
            PH_IDLE: begin
            end
            PH_T1: begin
                bus_out = cur.addr[BUS_W-1:0];
                lo_en   = 1'b1;
                hi_en   = 1'b1;
                astb    = 1'b1;
                hi_astb = cur.wide;
            end
            PH_T2, PH_T3, PH_TW: begin
                bus_out = data_word;
                lo_en   = cur.wr;
                hi_en   = cur.wr | cur.byte_m;
                rd_n    = cur.wr;
                wr_n    = !cur.wr;
            end
            PH_T4: begin
                bus_out = data_word;
                lo_en   = cur.wr;
                hi_en   = cur.wr | cur.byte_m;
                done    = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign bus_oe_lo  = lo_en & grant;
    assign bus_oe_hi  = hi_en & grant;
    assign ctl_oe     = grant;
    assign hi_astb_oe = grant & cur.wide;
    assign up_addr    = cur.addr[ADDR_W-1:BUS_W];

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
    assert_astb_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        astb |-> (rd_n && wr_n && !done));
    assert_wr_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && done) == 1'b0);
endmodule

// File: rtl/dma_rd_capture.sv
module dma_rd_capture
    import dma_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  phase_e           phase,
    input  logic             ready,
    input  req_t             cur,
    input  logic [BUS_W-1:0] bus_in,
    output logic [BUS_W-1:0] rdata
);
    logic last_rd_phase;

    assign last_rd_phase = !cur.wr && ((phase == PH_T3 && !ready) || phase == PH_TW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (last_rd_phase) begin
            rdata <= cur.byte_m ? {{(BUS_W-HALF_W){1'b0}}, bus_in[HALF_W-1:0]} : bus_in;
        end
    end

    assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        phase != PH_T4 |-> $stable(rdata));
endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
    import dma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_grant,
    input  logic              start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_byte,
    input  logic              req_wide,
    input  logic [BUS_W-1:0]  req_wdata,
    input  logic              ready,
    input  logic [BUS_W-1:0]  bus_in,
    output logic [BUS_W-1:0]  bus_out,
    output logic              bus_oe_lo,
    output logic              bus_oe_hi,
    output logic              astb,
    output logic              rd_n,
    output logic              wr_n,
    output logic              ctl_oe,
    output logic              hi_astb,
    output logic              hi_astb_oe,
    output logic [BUS_W-1:0]  up_addr,
    output logic [BUS_W-1:0]  rdata,
    output logic              done
);
    phase_e phase;
    req_t   req_in;
    req_t   cur;

    assign req_in = '{addr: req_addr, wr: req_write, byte_m: req_byte,
                      wide: req_wide, wdata: req_wdata};

    dma_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .grant(bus_grant), .start(start),
        .ready(ready), .req_in(req_in), .phase(phase), .cur(cur)
    );

    dma_bus_drive u_drv (
        .clk(clk), .rst_n(rst_n), .grant(bus_grant), .phase(phase), .cur(cur),
        .bus_out(bus_out), .bus_oe_lo(bus_oe_lo), .bus_oe_hi(bus_oe_hi),
        .astb(astb), .rd_n(rd_n), .wr_n(wr_n), .ctl_oe(ctl_oe),
        .hi_astb(hi_astb), .hi_astb_oe(hi_astb_oe), .up_addr(up_addr), .done(done)
    );

    dma_rd_capture u_cap (
        .clk(clk), .rst_n(rst_n), .phase(phase), .ready(ready), .cur(cur),
        .bus_in(bus_in), .rdata(rdata)
    );

    assert_grant_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_grant |-> !(bus_oe_lo || bus_oe_hi || ctl_oe || hi_astb_oe));
endmodule

// File: tb/sim_dma_cycle_seq.sv
module sim_dma_cycle_seq;
    localparam int PERIOD = 10;
    localparam int NCYC   = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_grant = 1'b0, start = 1'b0, req_write = 1'b0;
    logic        req_byte = 1'b0, req_wide = 1'b0, ready = 1'b0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_wdata = '0, bus_in = '0;
    logic [15:0] bus_out, up_addr, rdata;
    logic        bus_oe_lo, bus_oe_hi, astb, rd_n, wr_n, ctl_oe, hi_astb, hi_astb_oe, done;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    dma_cycle_seq u0 (
        .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant), .start(start),
        .req_addr(req_addr), .req_write(req_write), .req_byte(req_byte),
        .req_wide(req_wide), .req_wdata(req_wdata), .ready(ready), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe_lo(bus_oe_lo), .bus_oe_hi(bus_oe_hi),
        .astb(astb), .rd_n(rd_n), .wr_n(wr_n), .ctl_oe(ctl_oe), .hi_astb(hi_astb),
        .hi_astb_oe(hi_astb_oe), .up_addr(up_addr), .rdata(rdata), .done(done)
    );

    // Behavioural reference: 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4
    int          ph;
    logic [31:0] m_addr;
    logic [15:0] m_wd, m_rdata;
    bit          m_wr, m_byte, m_wide;
    int          n_wait = 0, n_b2b = 0, n_byte_rd = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= 0; m_addr <= '0; m_wd <= '0; m_rdata <= '0;
            m_wr <= 0; m_byte <= 0; m_wide <= 0;
        end else begin
            if ((ph == 0 || ph == 5) && start && bus_grant) begin
                ph <= 1;
                m_addr <= req_addr; m_wd <= req_wdata;
                m_wr <= req_write; m_byte <= req_byte; m_wide <= req_wide;
                if (ph == 5) n_b2b++;
            end else if (ph == 5 || ph == 0) begin
                ph <= 0;
            end else if (ph == 3 && ready) begin
                ph <= 4;
                n_wait++;
            end else if (ph == 3 || ph == 4) begin
                ph <= 5;
                if (!m_wr) begin
                    m_rdata <= m_byte ? {8'h00, bus_in[7:0]} : bus_in;
                    if (m_byte) n_byte_rd++;
                end
            end else begin
                ph <= ph + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            bit e_lo, e_hi, e_rdn, e_wrn;
            logic [15:0] e_bus;
            string dreq;
            e_lo = 0; e_hi = 0; e_bus = '0;
            if (ph == 1) begin
                e_lo = 1; e_hi = 1; e_bus = m_addr[15:0];
            end else if (ph >= 2) begin
                e_lo = m_wr; e_hi = m_wr || m_byte;
                e_bus = {m_byte ? m_addr[15:8] : m_wd[15:8], m_wd[7:0]};
            end
            e_rdn = !(!m_wr && ph >= 2 && ph <= 4);
            e_wrn = !(m_wr && ph >= 2 && ph <= 4);
            dreq = m_byte ? "R5" : "R4";
            if (!rst_n) begin
                chk(rd_n == 1 && wr_n == 1, "R1", "strobes", {rd_n, wr_n}, 2'b11);
                chk(astb == 0 && hi_astb == 0 && done == 0, "R1", "astb/done",
                    {astb, hi_astb, done}, 3'b000);
                chk(rdata == 16'h0, "R1", "rdata", rdata, 16'h0);
            end else begin
                if (!bus_grant)
                    chk({bus_oe_lo, bus_oe_hi, ctl_oe, hi_astb_oe} == 4'b0, "R9", "enables",
                        {bus_oe_lo, bus_oe_hi, ctl_oe, hi_astb_oe}, 4'b0);
                else begin
                    chk(bus_oe_lo == e_lo && bus_oe_hi == e_hi, (ph == 1) ? "R3" : dreq,
                        "bus enables", {bus_oe_hi, bus_oe_lo}, {e_hi, e_lo});
                    chk(ctl_oe == 1'b1, "R9", "ctl_oe", ctl_oe, 1'b1);
                    chk(hi_astb_oe == m_wide, "R10", "hi_astb_oe", hi_astb_oe, m_wide);
                end
                if (ph == 1)
                    chk(bus_out == e_bus, "R3", "address on bus", bus_out, e_bus);
                else if (ph >= 2) begin
                    if (e_hi) chk(bus_out[15:8] == e_bus[15:8], dreq, "bus high half",
                                  bus_out[15:8], e_bus[15:8]);
                    if (e_lo) chk(bus_out[7:0] == e_bus[7:0], dreq, "bus low half",
                                  bus_out[7:0], e_bus[7:0]);
                end
                chk(astb == (ph == 1), (ph == 1) ? "R2" : "R3", "astb", astb, ph == 1);
                chk(hi_astb == (ph == 1 && m_wide), "R10", "hi_astb", hi_astb,
                    ph == 1 && m_wide);
                if (m_wide) chk(up_addr == m_addr[31:16], "R10", "up_addr", up_addr,
                                m_addr[31:16]);
                chk(wr_n == e_wrn, (ph == 4) ? "R8" : "R6", "wr_n", wr_n, e_wrn);
                chk(rd_n == e_rdn, (ph == 4) ? "R8" : "R7", "rd_n", rd_n, e_rdn);
                chk(rdata == m_rdata, "R7", "rdata", rdata, m_rdata);
                chk(done == (ph == 5), "R11", "done", done, ph == 5);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < NCYC; i++) begin
            @(negedge clk);
            #1;
            bus_grant = !((i % 400) >= 350 && (i % 400) < 380);
            start     = ($urandom_range(0, 99) < 45);
            req_addr  = $urandom;
            req_wdata = $urandom;
            req_write = $urandom_range(0, 1);
            req_byte  = $urandom_range(0, 1);
            req_wide  = $urandom_range(0, 1);
            ready     = $urandom_range(0, 1);
            bus_in    = $urandom;
        end
        @(negedge clk);
        #1 start = 1'b0;
        repeat (8) @(negedge clk);
        chk(n_wait > 0 && n_b2b > 0 && n_byte_rd > 0, "R8", "scenario coverage",
            n_wait, 1);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule